// File: doc/BRIEF.md
# I2S Bit Clock, Word Strobe and Sample Interrupt Generator

This block times a stereo audio serial port. As clock master, it divides the system clock by a programmable 8-bit value. From that it makes a bit clock and a word strobe that marks 32-bit left and right slots. It raises a one-cycle interrupt at selected word boundaries so that software can supply the next sample. As clock slave, it produces no clocks. Its interrupt then follows an external word strobe, which is first resynchronised to the system clock.

A mode register selects master or slave operation, drive of the strobe output, and which strobe transitions raise the interrupt. Writing a new divider value restarts the timing at once. A two-bit status output reports the current strobe level and whether the left slot is active. Data shifting is handled elsewhere.

Top module: `i2s_word_timer`

## Requirements
- R1: Only bits [7:0] of a 16-bit divider write are stored as the divider value N; bits [15:8] are ignored.
- R2: In master mode the bit clock starts low after a restart and toggles every N+1 system clocks. The word strobe starts low and toggles every 64·(N+1) system clocks, so its first transition is rising and comes 64·(N+1) clocks after the restart.
- R3: After reset N is 8 and the mode register is 0 (slave mode, no interrupt sources). The bit clock, the word strobe and the interrupt are low, and the status reads 2'b10.
- R4: A divider write in master mode clears all timing at once: the bit clock and strobe go low. If the falling-edge or every-word source is enabled, an interrupt pulse follows in the next cycle. The restart counts as the start of a left word.
- R5: Mode bit 0 selects master mode. Mode bit 5 (every word) raises an interrupt on every strobe transition, which is every 64·(N+1) clocks in master mode.
- R6: Mode bit 3 raises an interrupt on strobe low-to-high transitions only. Mode bit 4 raises one on high-to-low transitions only. With bits 3, 4 and 5 all clear, no interrupt occurs.
- R7: Mode bit 2 drives the internal strobe onto the strobe output. When bit 2 is clear, the output stays low, and the interrupts and status are unchanged.
- R8: The interrupt is a single-cycle pulse. In master mode it goes high in the same cycle as the strobe transition that causes it.
- R9: In slave mode the bit clock and strobe outputs stay low, and divider writes raise no interrupt. The external strobe passes through two synchronising flops and an edge detector, so the interrupt appears after the third rising clock edge following a change.
- R10: Status bit 0 gives the current strobe level: the internal strobe in master mode, or the synchronised external strobe in slave mode. Status bit 1 is its inverse and is high during the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 16 | Divider write data, low byte used |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 6 | Mode value: bit0 master, bit2 strobe drive, bit3 rising, bit4 falling, bit5 every word |
| ext_ws | input | 1 | External word strobe, asynchronous |
| sclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word strobe output |
| irq_o | output | 1 | Sample interrupt pulse |
| status_o | output | 2 | {left slot, strobe level} |

## Verification
A half-period counter that is off by one changes the interrupt spacing by 64 cycles per word, so one measured interval between interrupts exposes it. A wrong bit-slot count or a wrong strobe phase shows in the first interval after a restart, through the strobe polarity and the status at the interrupt. A restart that does not clear the counters moves the next interrupt away from exactly 64·(N+1) clocks. A bad synchroniser depth moves the slave-mode interrupt away from the third clock edge after the external strobe changes.

// File: rtl/i2s_word_timer.sv
module i2s_word_timer #(
  parameter int DIV_W     = 8,
  parameter int WDATA_W   = 16,
  parameter int SLOT_BITS = 32,
  parameter int DIV_INIT  = 8,
  parameter int MODE_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_wr,
  input  logic [WDATA_W-1:0] div_wdata,
  input  logic               mode_wr,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               ext_ws,
  output logic               sclk_o,
  output logic               ws_o,
  output logic               irq_o,
  output logic [1:0]         status_o
);
  localparam int BCW = $clog2(SLOT_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(SLOT_BITS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [MODE_W-1:0] mode_q;
  logic [DIV_W-1:0]  hcnt;
  logic [BCW-1:0]    bcnt;
  logic              sclk_q, ws_q;
  logic [2:0]        sync_q;

  wire int_mode = mode_q[0];
  wire ws_en    = mode_q[2];
  wire on_rise  = mode_q[3];
  wire on_fall  = mode_q[4];
  wire every    = mode_q[5];
  wire unused_bits = ^{div_wdata[WDATA_W-1:DIV_W], mode_q[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_INIT);
      mode_q <= '0;
    end else begin
      if (div_wr)  div_q  <= div_wdata[DIV_W-1:0];
      if (mode_wr) mode_q <= mode_wdata;
    end
  end

  wire half_done = (hcnt == div_q);
  wire slot_end  = half_done && sclk_q && (bcnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !int_mode || div_wr) begin
      hcnt   <= '0;
      bcnt   <= '0;
      sclk_q <= 1'b0;
      ws_q   <= 1'b0;
    end else if (half_done) begin
      hcnt   <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) bcnt <= (bcnt == LAST_BIT) ? '0 : bcnt + BCW'(1);
      if (slot_end) ws_q <= ~ws_q;
    end else begin
      hcnt <= hcnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_ws};
  end

  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire ext_fall = ~sync_q[1] & sync_q[2];
  wire int_rise = slot_end & ~ws_q & ~div_wr;
  wire int_fall = slot_end & ws_q & ~div_wr;
  wire restart  = int_mode & div_wr;

  wire rise_ev = int_mode ? int_rise : ext_rise;
  wire fall_ev = int_mode ? int_fall : ext_fall;
  wire irq_d   = (rise_ev & (on_rise | every)) |
                 (fall_ev & (on_fall | every)) |
                 (restart & (on_fall | every));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end

  wire cur_ws = int_mode ? ws_q : sync_q[1];
  assign status_o = {~cur_ws, cur_ws};
  assign sclk_o   = sclk_q;
  assign ws_o     = int_mode & ws_en & ws_q;
endmodule

// File: rtl/i2s_word_timer_chk.sv
module i2s_word_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       div_wr,
  input logic       mode_wr,
  input logic [5:0] mode,
  input logic       sclk,
  input logic       irq,
  input logic [1:0] stat
);
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && div_wr && !mode_wr) |=> (!sclk && !stat[0])); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && irq && !div_wr && !mode_wr) |=> !irq); // R8

  AST_SLAVE_NO_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] |=> !sclk); // R9

  AST_RISE_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && $past(mode[0]) && !$past(mode_wr) && mode[5:3] == 3'b001 && irq) |-> stat[0]); // R6

  AST_WS_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && $past(mode[0]) && !$past(div_wr) && !$stable(stat[0])) |-> $fell(sclk)); // R2
endmodule

bind i2s_word_timer i2s_word_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .mode_wr(mode_wr),
  .mode(mode_q), .sclk(sclk_o), .irq(irq_o), .stat(status_o)
);

// File: tb/i2s_word_timer_test.sv
module i2s_word_timer_test;
  logic clk = 0, rst_n = 0, div_wr = 0, mode_wr = 0, ext_ws = 0;
  logic [15:0] div_wdata = '0;
  logic [5:0]  mode_wdata = '0;
  logic sclk_o, ws_o, irq_o;
  logic [1:0] status_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  i2s_word_timer uut (.clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .ext_ws(ext_ws), .sclk_o(sclk_o),
    .ws_o(ws_o), .irq_o(irq_o), .status_o(status_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [15:0] d);
    @(negedge clk); div_wr = 1; div_wdata = d;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic wr_mode(input logic [5:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_o && n < 3000);
  endtask

  task automatic t_reset;
    chk("R3 sclk", sclk_o, 0);
    chk("R3 ws", ws_o, 0);
    chk("R3 irq", irq_o, 0);
    chk("R3 status", status_o, 2);
  endtask

  task automatic t_default_div;
    int n;
    wr_mode(6'b100101);
    wait_irq(n);
    chk("R3 default divider interval", n, 576);
    chk("R2 first transition rising", ws_o, 1);
    chk("R10 status high", status_o, 1);
    @(negedge clk);
    chk("R8 pulse width", irq_o, 0);
    wait_irq(n);
    chk("R5 every word interval", n, 575);
    chk("R5 second transition falling", ws_o, 0);
  endtask

  task automatic t_low_byte;
    int n;
    wr_div(16'hAB03);
    chk("R4 restart pulse", irq_o, 1);
    chk("R4 sclk cleared", sclk_o, 0);
    chk("R4 ws cleared", ws_o, 0);
    wait_irq(n);
    chk("R1 low byte interval", n, 256);
  endtask

  task automatic t_sclk;
    int n = 0;
    wr_div(16'h0003);
    do begin @(negedge clk); n++; end while (!sclk_o && n < 100);
    chk("R2 sclk low half", n, 4);
    n = 0;
    do begin @(negedge clk); n++; end while (sclk_o && n < 100);
    chk("R2 sclk high half", n, 4);
  endtask

  task automatic t_restart;
    int n;
    wr_div(16'h0003);
    repeat (100) @(negedge clk);
    wr_div(16'h0003);
    chk("R4 mid-word restart pulse", irq_o, 1);
    wait_irq(n);
    chk("R4 interval after restart", n, 256);
  endtask

  task automatic t_rise_only;
    int n;
    wr_mode(6'b001101);
    wr_div(16'h0003);
    chk("R4 no restart pulse when rise only", irq_o, 0);
    wait_irq(n);
    chk("R6 rise only first", n, 256);
    chk("R6 ws high at rise irq", ws_o, 1);
    wait_irq(n);
    chk("R6 rise only skips fall", n, 512);
  endtask

  task automatic t_fall_only;
    int n;
    wr_mode(6'b010101);
    wr_div(16'h0003);
    chk("R4 restart pulse fall only", irq_o, 1);
    wait_irq(n);
    chk("R6 fall only skips rise", n, 512);
    chk("R6 ws low at fall irq", ws_o, 0);
    chk("R10 left slot status", status_o, 2);
  endtask

  task automatic t_wsen;
    int n;
    wr_mode(6'b100001);
    wr_div(16'h0003);
    wait_irq(n);
    chk("R7 irq unaffected", n, 256);
    chk("R7 ws output held low", ws_o, 0);
    chk("R7 status still follows strobe", status_o, 1);
  endtask

  task automatic t_slave;
    int n, hits;
    wr_mode(6'b011000);
    wr_div(16'h0005);
    chk("R9 no restart pulse in slave", irq_o, 0);
    hits = 0;
    repeat (300) begin @(negedge clk); if (sclk_o || ws_o || irq_o) hits++; end
    chk("R9 outputs idle in slave", hits, 0);
    ext_ws = 1; n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 2) chk("R10 synced strobe status", status_o, 1);
    end while (!irq_o && n < 20);
    chk("R9 rise latency", n, 3);
    @(negedge clk);
    chk("R8 slave pulse width", irq_o, 0);
    ext_ws = 0;
    wait_irq(n);
    chk("R9 fall latency", n, 3);
    wr_mode(6'b001000);
    ext_ws = 1; repeat (10) @(negedge clk);
    ext_ws = 0; hits = 0;
    repeat (10) begin @(negedge clk); if (irq_o) hits++; end
    chk("R6 slave rise only ignores fall", hits, 0);
    wr_mode(6'b000000);
    ext_ws = 1; hits = 0;
    repeat (10) begin @(negedge clk); if (irq_o) hits++; end
    chk("R6 no sources no irq", hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_default_div;
    t_low_byte;
    t_sclk;
    t_restart;
    t_rise_only;
    t_fall_only;
    t_wsen;
    t_slave;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule